// File: doc/BRIEF.md
# Battery capacity learning counters

This block keeps the running charge balance of a rechargeable pack and learns the pack's real full-charge capacity from experience. Upstream logic delivers single-cycle count pulses that have already been corrected for rate and temperature: charge pulses, discharge pulses and self-discharge pulses. It also delivers a handful of qualifiers: the pack voltage is below the empty level, an overload is present, the pack is below freezing, a valid charge has started, and a fast-to-trickle charge change has been seen.

The block holds three 16-bit counts: the remaining capacity, the learned full capacity and the discharge count. The discharge count measures one full-to-empty discharge. It keeps running after the remaining count has bottomed out. When that discharge meets every qualification rule, its count becomes the new full reference at the next valid charge. A counter of charges since the last learning event drives a capacity-inaccurate flag. A synchronous clear command returns everything to the power-on state. While the full reference has not yet been learned, it tracks the programmed capacity input.

Top module: `cap_learn`

## Requirements
- R1: After reset or a clear command, the remaining count and the discharge count read 0. The learned full count equals the programmed full input, the charge-event count reads 0, the inaccurate flag is 1, and the qualification and empty flags are 0.
- R2: A charge pulse raises the remaining count by 1 and saturates at the learned full count. Each discharge pulse and each self-discharge pulse lowers it by 1, saturating at 0. A charge pulse and a discharge pulse in the same cycle cancel, but a self-discharge pulse in that cycle still counts.
- R3: A voltage-low indication with no overload and no valid charge in that cycle sets the empty flag and forces the remaining count to 0 in the next cycle. While the overload input is high, the empty flag is not set. A valid charge clears the empty flag.
- R4: The discharge count rises by 1 for each discharge pulse, whatever the remaining count. It also rises by 1 for each self-discharge pulse, but only while the remaining count is nonzero. It saturates at 0xFFFF and does not wrap.
- R5: The qualification flag sets, and the discharge count and the accumulated self-discharge clear, on either of two events. One is a charge pulse while the remaining count equals the full count. The other is a trickle strobe while the remaining count is above the 80% threshold. The flag clears when the empty flag is set.
- R6: A discharge is qualified only if three conditions hold when the empty flag sets. No valid charge may have occurred while the qualification flag was set. No more self-discharge pulses may have accumulated since qualification than the 10% limit, which is floor(programmed_full*26/256). The cold input must be low.
- R7: The first valid charge after a qualified empty loads the learned full count with the larger of two values: the discharge count, and the 75% threshold floor(full*192/256).
- R8: On a trickle strobe, if the remaining count is above floor(full*205/256) and at most floor(full*218/256), the remaining count is set to floor(full*218/256). Otherwise it is unchanged by the strobe.
- R9: The charge-event count rises by 1 on each valid charge, saturates at 255 and clears when the full count is learned.
- R10: The inaccurate flag sets when the charge-event count reaches 64 and clears when the full count is learned.
- R11: In a learning cycle, the remaining count, the discharge count and the charge-event count take no pulse updates from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear command |
| prog_full_i | input | 16 | Programmed full capacity |
| chg_i | input | 1 | Compensated charge pulse |
| dsg_i | input | 1 | Compensated discharge pulse |
| sdsg_i | input | 1 | Self-discharge pulse |
| vlow_i | input | 1 | Pack voltage below empty level |
| ovld_i | input | 1 | Overload present, blocks empty detection |
| cold_i | input | 1 | Temperature below 0 degrees C |
| vchg_i | input | 1 | Valid charge strobe |
| trickle_i | input | 1 | Fast-to-trickle transition strobe |
| remain_o | output | 16 | Remaining capacity count |
| full_o | output | 16 | Learned full capacity count |
| dcount_o | output | 16 | Discharge count |
| qual_o | output | 1 | Qualification flag |
| empty_o | output | 1 | Empty flag |
| events_o | output | 8 | Valid charges since last learning |
| inacc_o | output | 1 | Capacity-inaccurate flag |

## Verification
Every state element except the hidden qualification bookkeeping reaches a port in the cycle after the edge that changes it, so a bad update to a count shows up one cycle later. A corrupted disqualify bit or self-discharge accumulator stays hidden until the next valid charge after empty. At that point it shows up as a full count that was learned or kept against the rules. The bench therefore runs whole charge-to-empty cycles, one for each disqualifying condition, and reads the full count after each final valid charge.

// File: rtl/cap_learn_pkg.sv
package cap_learn_pkg;
  localparam int FRAC_SH = 8;
  localparam int N_THR   = 3;
  localparam int THR_P75 = 0;
  localparam int THR_P80 = 1;
  localparam int THR_P85 = 2;
  localparam int THR_NUM [N_THR] = '{192, 205, 218};
  localparam int SD_NUM  = 26;

  // floor(v * num / 2^FRAC_SH)
  function automatic logic [31:0] frac_of(input logic [31:0] v, input int num);
    logic [47:0] p;
    p = 48'(v) * 48'(num);
    return p[FRAC_SH +: 32];
  endfunction
endpackage

// File: rtl/cap_thresh.sv
module cap_thresh import cap_learn_pkg::*; #(
  parameter int CW = 16
) (
  input  logic [CW-1:0]              full_i,
  input  logic [CW-1:0]              prog_i,
  output logic [N_THR-1:0][CW-1:0]   thr_o,
  output logic [CW-1:0]              sd_lim_o
);
  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    assign thr_o[g] = CW'(frac_of(32'(full_i), THR_NUM[g]));
  end
  assign sd_lim_o = CW'(frac_of(32'(prog_i), SD_NUM));
endmodule

// File: rtl/cap_remain.sv
module cap_remain #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hold_i,
  input  logic          zero_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          up_i,
  input  logic [1:0]    dn_i,
  input  logic [CW-1:0] full_i,
  output logic [CW-1:0] remain_o
);
  logic [CW-1:0] remain_q;
  logic [CW+1:0] sum, nxt;

  always_comb begin
    sum = {2'b00, remain_q} + {{(CW+1){1'b0}}, up_i};
    if (sum < {{CW{1'b0}}, dn_i}) nxt = '0;
    else                          nxt = sum - {{CW{1'b0}}, dn_i};
    if (nxt > {2'b00, full_i})    nxt = {2'b00, full_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      remain_q <= '0;
    else if (clr_i)   remain_q <= '0;
    else if (hold_i)  remain_q <= remain_q;
    else if (zero_i)  remain_q <= '0;
    else if (load_i)  remain_q <= load_val_i;
    else              remain_q <= nxt[CW-1:0];
  end

  assign remain_o = remain_q;

  a_r2_floor_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q == '0 && !up_i && !load_i) |=> remain_q == '0);
  a_r2_no_rise_without_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && !load_i && !clr_i) |=> remain_q <= $past(remain_q));
endmodule

// File: rtl/cap_dcount.sv
module cap_dcount #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hold_i,
  input  logic          restart_i,
  input  logic          dsg_i,
  input  logic          sdsg_i,
  input  logic          remain_nz_i,
  input  logic          track_i,
  output logic [CW-1:0] dcount_o,
  output logic [CW-1:0] sd_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] dcount_q, sd_q;
  logic [1:0]    inc;
  logic [CW+1:0] dsum;

  assign inc  = {1'b0, dsg_i} + {1'b0, sdsg_i & remain_nz_i};
  assign dsum = {2'b00, dcount_q} + {{CW{1'b0}}, inc};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcount_q <= '0;
      sd_q     <= '0;
    end else if (clr_i || restart_i) begin
      dcount_q <= '0;
      sd_q     <= '0;
    end else if (!hold_i) begin
      dcount_q <= (dsum > {2'b00, CMAX}) ? CMAX : dsum[CW-1:0];
      if (track_i && sdsg_i && sd_q != CMAX) sd_q <= sd_q + 1'b1;
    end
  end

  assign dcount_o = dcount_q;
  assign sd_o     = sd_q;

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcount_q == CMAX && !clr_i && !restart_i) |=> dcount_q == CMAX);
  a_r4_empty_ignores_sd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!remain_nz_i && !dsg_i && !clr_i && !restart_i) |=> $stable(dcount_q));
endmodule

// File: rtl/cap_learn.sv
module cap_learn import cap_learn_pkg::*; #(
  parameter int CW       = 16,
  parameter int EW       = 8,
  parameter int INACC_AT = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] prog_full_i,
  input  logic          chg_i,
  input  logic          dsg_i,
  input  logic          sdsg_i,
  input  logic          vlow_i,
  input  logic          ovld_i,
  input  logic          cold_i,
  input  logic          vchg_i,
  input  logic          trickle_i,
  output logic [CW-1:0] remain_o,
  output logic [CW-1:0] full_o,
  output logic [CW-1:0] dcount_o,
  output logic          qual_o,
  output logic          empty_o,
  output logic [EW-1:0] events_o,
  output logic          inacc_o
);
  localparam logic [EW-1:0] EV_MAX = '1;

  logic                    loaded_q, qual_q, disq_q, pend_q, empty_q, inacc_q;
  logic [CW-1:0]           full_q, full_eff, remain, dcount, sd_acc, sd_lim;
  logic [EW-1:0]           ev_q;
  logic [N_THR-1:0][CW-1:0] thr;
  logic                    chg_eff, dsg_eff, learn, empty_set, qual_set, trk_load;
  logic [1:0]              dn;

  assign full_eff  = loaded_q ? full_q : prog_full_i;
  assign chg_eff   = chg_i & ~dsg_i;
  assign dsg_eff   = dsg_i & ~chg_i;
  assign dn        = {1'b0, dsg_eff} + {1'b0, sdsg_i};
  assign learn     = vchg_i & pend_q;
  assign empty_set = vlow_i & ~ovld_i & ~vchg_i & ~empty_q;
  assign trk_load  = trickle_i & (remain > thr[THR_P80]) & (remain <= thr[THR_P85]);
  assign qual_set  = ~qual_q & ~empty_q &
                     ((chg_eff & (remain == full_eff)) | (trickle_i & (remain > thr[THR_P80])));

  cap_thresh #(.CW(CW)) u_thr (
    .full_i(full_eff), .prog_i(prog_full_i), .thr_o(thr), .sd_lim_o(sd_lim)
  );

  cap_remain #(.CW(CW)) u_rem (
    .clk_i, .rst_ni, .clr_i,
    .hold_i(learn), .zero_i(empty_set), .load_i(trk_load),
    .load_val_i(thr[THR_P85]), .up_i(chg_eff), .dn_i(dn),
    .full_i(full_eff), .remain_o(remain)
  );

  cap_dcount #(.CW(CW)) u_dc (
    .clk_i, .rst_ni, .clr_i,
    .hold_i(learn), .restart_i(qual_set), .dsg_i(dsg_eff), .sdsg_i(sdsg_i),
    .remain_nz_i(remain != '0), .track_i(qual_q),
    .dcount_o(dcount), .sd_o(sd_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      full_q   <= '0;
      qual_q   <= 1'b0;
      disq_q   <= 1'b0;
      pend_q   <= 1'b0;
      empty_q  <= 1'b0;
      ev_q     <= '0;
      inacc_q  <= 1'b1;
    end else if (clr_i) begin
      loaded_q <= 1'b0;
      full_q   <= '0;
      qual_q   <= 1'b0;
      disq_q   <= 1'b0;
      pend_q   <= 1'b0;
      empty_q  <= 1'b0;
      ev_q     <= '0;
      inacc_q  <= 1'b1;
    end else begin
      if (learn) begin
        loaded_q <= 1'b1;
        full_q   <= (dcount > thr[THR_P75]) ? dcount : thr[THR_P75];
      end
      if (empty_set)     qual_q <= 1'b0;
      else if (qual_set) qual_q <= 1'b1;
      if (qual_set)                disq_q <= 1'b0;
      else if (qual_q && vchg_i)   disq_q <= 1'b1;
      if (empty_set)   pend_q <= qual_q & ~disq_q & (sd_acc <= sd_lim) & ~cold_i;
      else if (vchg_i) pend_q <= 1'b0;
      if (vchg_i)         empty_q <= 1'b0;
      else if (empty_set) empty_q <= 1'b1;
      if (learn) begin
        ev_q    <= '0;
        inacc_q <= 1'b0;
      end else if (vchg_i) begin
        if (ev_q != EV_MAX) ev_q <= ev_q + 1'b1;
        if (32'(ev_q) >= INACC_AT - 1) inacc_q <= 1'b1;
      end
    end
  end

  assign remain_o = remain;
  assign full_o   = full_eff;
  assign dcount_o = dcount;
  assign qual_o   = qual_q;
  assign empty_o  = empty_q;
  assign events_o = ev_q;
  assign inacc_o  = inacc_q;

  a_r3_zero_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_set && !clr_i) |=> (remain == '0 && empty_q));
  a_r5_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_set && !clr_i) |=> (dcount == '0 && qual_q));
  a_r7_learn_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (learn && !clr_i) |=> full_eff >= $past(thr[THR_P75]));
  a_r9_event_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_q == EV_MAX && !learn && !clr_i) |=> ev_q == EV_MAX);
  a_r10_flag_follows_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(ev_q) >= INACC_AT) |-> inacc_q);
endmodule

// File: tb/cap_learn_test.sv
module cap_learn_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic [15:0] prog_full_i = 16'd1000;
  logic        chg_i = 1'b0, dsg_i = 1'b0, sdsg_i = 1'b0, vlow_i = 1'b0;
  logic        ovld_i = 1'b0, cold_i = 1'b0, vchg_i = 1'b0, trickle_i = 1'b0;
  logic [15:0] remain_o, full_o, dcount_o;
  logic        qual_o, empty_o, inacc_o;
  logic [7:0]  events_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  cap_learn uut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock with the given strobes; returns 1 ns after the edge
  task automatic step(input logic c, d, s, vl, ov, cd, vc, tr);
    chg_i = c; dsg_i = d; sdsg_i = s; vlow_i = vl;
    ovld_i = ov; cold_i = cd; vchg_i = vc; trickle_i = tr;
    @(posedge clk_i); #1;
    chg_i = 0; dsg_i = 0; sdsg_i = 0; vlow_i = 0;
    ovld_i = 0; cold_i = 0; vchg_i = 0; trickle_i = 0;
  endtask

  task automatic chg_n(input int n);
    for (int i = 0; i < n; i++) step(1,0,0,0,0,0,0,0);
  endtask
  task automatic dsg_n(input int n);
    for (int i = 0; i < n; i++) step(0,1,0,0,0,0,0,0);
  endtask
  task automatic sd_n(input int n);
    for (int i = 0; i < n; i++) step(0,0,1,0,0,0,0,0);
  endtask
  task automatic vchg_n(input int n);
    for (int i = 0; i < n; i++) step(0,0,0,0,0,0,1,0);
  endtask

  task automatic t_reset;
    chk("R1", "remain", remain_o, 0);
    chk("R1", "full", full_o, 1000);
    chk("R1", "dcount", dcount_o, 0);
    chk("R1", "events", events_o, 0);
    chk("R1", "inacc", inacc_o, 1);
    chk("R1", "qual", qual_o, 0);
    chk("R1", "empty", empty_o, 0);
  endtask

  task automatic t_count;
    chg_n(5);                    chk("R2", "up", remain_o, 5);
    step(1,1,0,0,0,0,0,0);       chk("R2", "cancel", remain_o, 5);
                                 chk("R4", "cancel dcount", dcount_o, 0);
    dsg_n(2);                    chk("R2", "down", remain_o, 3);
                                 chk("R4", "dsg inc", dcount_o, 2);
    sd_n(1);                     chk("R4", "sd inc nonzero", dcount_o, 3);
    step(0,1,1,0,0,0,0,0);       chk("R2", "dual dec", remain_o, 0);
                                 chk("R4", "dual inc", dcount_o, 5);
    sd_n(1);                     chk("R2", "floor", remain_o, 0);
                                 chk("R4", "sd at zero", dcount_o, 5);
    dsg_n(1);                    chk("R4", "dsg at zero", dcount_o, 6);
  endtask

  task automatic t_full;
    chg_n(1000);                 chk("R2", "reach full", remain_o, 1000);
                                 chk("R5", "not yet qual", qual_o, 0);
                                 chk("R5", "dcount kept", dcount_o, 6);
    chg_n(1);                    chk("R2", "ceiling", remain_o, 1000);
                                 chk("R5", "qual set", qual_o, 1);
                                 chk("R5", "dcount cleared", dcount_o, 0);
  endtask

  task automatic t_learn;
    dsg_n(1000);                 chk("R4", "full discharge", dcount_o, 1000);
    sd_n(3);                     chk("R4", "sd ignored at 0", dcount_o, 1000);
    dsg_n(5);                    chk("R4", "beyond zero", dcount_o, 1005);
    step(0,0,0,1,1,0,0,0);       chk("R3", "overload blocks", empty_o, 0);
    step(0,0,0,1,0,0,0,0);       chk("R3", "empty set", empty_o, 1);
                                 chk("R5", "qual clears", qual_o, 0);
    chg_n(1);                    chk("R2", "charge after empty", remain_o, 1);
    step(0,1,0,0,0,0,1,0);       chk("R7", "learn up", full_o, 1005);
                                 chk("R11", "remain held", remain_o, 1);
                                 chk("R11", "dcount held", dcount_o, 1005);
                                 chk("R9", "events clear", events_o, 0);
                                 chk("R10", "inacc clear", inacc_o, 0);
                                 chk("R3", "empty cleared", empty_o, 0);
  endtask

  task automatic t_clamp;
    chg_n(1005);                 chk("R5", "qual again", qual_o, 1);
    dsg_n(100);                  chk("R2", "partial", remain_o, 905);
    step(0,0,0,1,0,0,0,0);       chk("R3", "forced zero", remain_o, 0);
    vchg_n(1);                   chk("R7", "clamped 75pct", full_o, 753);
  endtask

  task automatic t_disq;
    chg_n(754); dsg_n(50);
    step(0,0,0,1,0,1,0,0); vchg_n(1);
    chk("R6", "cold blocks", full_o, 753);
    chk("R9", "event count", events_o, 1);
    chg_n(754); sd_n(102);
    chk("R4", "sd counted", dcount_o, 102);
    step(0,0,0,1,0,0,0,0); vchg_n(1);
    chk("R6", "self-discharge blocks", full_o, 753);
    chg_n(754); vchg_n(1); dsg_n(10);
    step(0,0,0,1,0,0,0,0); vchg_n(1);
    chk("R6", "charge in window blocks", full_o, 753);
    chk("R9", "event count 4", events_o, 4);
  endtask

  task automatic t_trickle;
    chg_n(602);
    step(0,0,0,0,0,0,0,1);       chk("R8", "at 80pct edge", remain_o, 602);
                                 chk("R5", "no qual at edge", qual_o, 0);
                                 chk("R5", "dcount kept", dcount_o, 10);
    chg_n(18);
    step(0,0,0,0,0,0,0,1);       chk("R8", "raised to 85pct", remain_o, 641);
                                 chk("R5", "qual by trickle", qual_o, 1);
                                 chk("R5", "dcount cleared", dcount_o, 0);
    chg_n(59);
    step(0,0,0,0,0,0,0,1);       chk("R8", "above 85pct kept", remain_o, 700);
  endtask

  task automatic t_events;
    vchg_n(59);                  chk("R9", "count 63", events_o, 63);
                                 chk("R10", "flag low at 63", inacc_o, 0);
    vchg_n(1);                   chk("R10", "flag at 64", inacc_o, 1);
    vchg_n(200);                 chk("R9", "saturate", events_o, 255);
  endtask

  task automatic t_dsat;
    dsg_n(700);                  chk("R4", "to zero", dcount_o, 700);
    dsg_n(64835);                chk("R4", "reach max", dcount_o, 65535);
    dsg_n(3);                    chk("R4", "no wrap", dcount_o, 65535);
  endtask

  task automatic t_clear;
    prog_full_i = 16'd2000;
    clr_i = 1'b1; step(0,0,0,0,0,0,0,0); clr_i = 1'b0;
    chk("R1", "clr remain", remain_o, 0);
    chk("R1", "clr full", full_o, 2000);
    chk("R1", "clr dcount", dcount_o, 0);
    chk("R1", "clr events", events_o, 0);
    chk("R1", "clr inacc", inacc_o, 1);
    chk("R1", "clr qual", qual_o, 0);
  endtask

  initial begin
    #7 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_count();
    t_full();
    t_learn();
    t_clamp();
    t_disq();
    t_trickle();
    t_events();
    t_dsat();
    t_clear();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule